// File: doc/BRIEF.md
# Fractional-Capable 8x8 Multiplier Unit

This unit multiplies two bytes and returns a 16-bit product for the low register pair of a small microcontroller core. A mode code selects one of three operand signedness combinations: both operands unsigned, both signed, or a signed first operand with an unsigned second. A separate mode bit asks for a fractional (1.7 fixed-point) result. In that case the unit shifts the product left by one place before it returns it, so the caller needs no further shift.

The core asserts a start strobe together with the operands and the mode. The unit captures them on that clock edge and computes the product during the following cycle. It then registers the result with two flags, zero and carry, and pulses done for one cycle. The carry is the top bit of the product before the fractional shift, so it still shows the sign or overflow of the raw multiply. The zero flag looks at the final value. Result and flags hold their values until the next operation completes.

Top module: `fmul_unit`

## Requirements
- R1: While rst_n is low at a clock edge, result, flag_z, flag_c and done are all cleared to zero on that edge.
- R2: Mode code 3'b000 multiplies op_a and op_b as unsigned values and returns the low 16 bits of the product.
- R3: Mode code 3'b001 multiplies op_a and op_b as two's-complement signed values and returns the 16-bit product.
- R4: Mode code 3'b010 treats op_a as signed and op_b as unsigned.
- R5: When mode bit 2 is set, the signedness comes from mode bits 1:0 as in R2 to R4, and the returned result is the 16-bit product shifted left by one bit, with bit 0 zero.
- R6: flag_c equals bit 15 of the 16-bit product taken before any fractional shift.
- R7: flag_z is 1 exactly when the returned 16-bit result is zero.
- R8: When start is sampled high at edge T with the unit idle, done is 1 for exactly the one cycle after edge T+1, and result and flags take their new values on edge T+1.
- R9: A start sampled on the edge that completes an accepted operation (edge T+1) is ignored: it produces no second done and does not change the result.
- R10: Outside a completing edge, result, flag_z and flag_c keep their previous values.
- R11: The unused signedness code 2'b11 in mode bits 1:0 behaves as unsigned by unsigned, with or without the fractional bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiply with the present operands and mode |
| mode | input | 3 | Bit 2 selects fractional; bits 1:0 select signedness (00 uu, 01 ss, 10 su) |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| result | output | 16 | Product, high byte in bits 15:8 |
| flag_z | output | 1 | Zero flag of the last result |
| flag_c | output | 1 | Carry flag: bit 15 of the unshifted product |
| done | output | 1 | One-cycle pulse when result and flags are updated |

## Verification
On every cycle the assertions check the handshake. A captured operation completes on the next edge with a done pulse. The capture stage never stays armed for two edges, so a start that arrives while it is busy cannot re-arm it. Result and flags stay still when nothing completes. The assertions also check that the carry matches the top result bit in non-fractional modes and that the zero flag matches the registered result. The product values themselves are shown only by the bench: directed corner cases with extreme signed and unsigned operands, zero operands, and the fractional shift dropping the top bit, followed by a long random stream of back-to-back and colliding starts over all eight mode codes. A behavioural model predicts every output of that stream on every cycle.

// File: rtl/fmul_pkg.sv
// Package: mode code layout and decode helpers shared by the multiplier unit.
// Assumes a 3-bit mode: bit 2 fractional, bits 1:0 signedness.
package fmul_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        SGN_UU   = 2'b00,
        SGN_SS   = 2'b01,
        SGN_SU   = 2'b10,
        SGN_RSVD = 2'b11
    } sign_sel_t;

    // First operand is signed for the SS and SU codes.
    function automatic logic first_signed(input logic [MODE_W-1:0] m);
        return (m[1:0] == SGN_SS) || (m[1:0] == SGN_SU);
    endfunction

    // Second operand is signed only for the SS code.
    function automatic logic second_signed(input logic [MODE_W-1:0] m);
        return (m[1:0] == SGN_SS);
    endfunction

    function automatic logic is_fractional(input logic [MODE_W-1:0] m);
        return m[2];
    endfunction
endpackage

// File: rtl/fmul_operand_ext.sv
// Module: extends one W-bit operand to W+1 bits, either by sign or by zero.
// Assumes the product stage treats the W+1-bit value as two's complement.
module fmul_operand_ext #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         as_signed,
    output logic [W:0]   ext
);
    // Top bit copies the sign only when the operand is declared signed.
    always_comb ext = {as_signed & val[W-1], val};
endmodule

// File: rtl/fmul_stage.sv
// Module: capture register for extended operands and the fractional bit.
// Assumes the parent asserts load only while the stage is empty; valid lasts one cycle.
module fmul_stage #(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [W:0] a_in,
    input  logic [W:0] b_in,
    input  logic       frac_in,
    output logic [W:0] a_q,
    output logic [W:0] b_q,
    output logic       frac_q,
    output logic       valid_q
);
    // Holds operands for the single compute cycle that follows a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            frac_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) begin
                a_q    <= a_in;
                b_q    <= b_in;
                frac_q <= frac_in;
            end
        end
    end

    // The stage never stays armed for two edges, so a start while busy cannot re-arm it.
    assert_busy_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
endmodule

// File: rtl/fmul_shaper.sv
// Module: signed multiply of the captured operands, fractional shift and flags.
// Assumes operands are already extended to W+1 bits; purely combinational.
module fmul_shaper #(
    parameter int W = 8
) (
    input  logic [W:0]     a_x,
    input  logic [W:0]     b_x,
    input  logic           frac,
    output logic [2*W-1:0] res,
    output logic           z,
    output logic           c
);
    localparam int FW = 2*W + 2;

    logic [FW-1:0]  a_w;
    logic [FW-1:0]  b_w;
    logic [FW-1:0]  full;
    logic [2*W-1:0] raw;

    // Sign-extend both operands to the full width, then multiply.
    always_comb begin
        a_w  = {{(W+1){a_x[W]}}, a_x};
        b_w  = {{(W+1){b_x[W]}}, b_x};
        full = a_w * b_w;
        raw  = full[2*W-1:0];
    end

    // Apply the fractional shift and derive the flags.
    always_comb begin
        res = frac ? {raw[2*W-2:0], 1'b0} : raw;
        c   = raw[2*W-1];
        z   = (res == '0);
    end
endmodule

// File: rtl/fmul_unit.sv
// Module: two-cycle 8x8 multiplier with signed, mixed and fractional modes.
// Assumes start is ignored while an operation is in the capture stage; the
// result and flags are registered and held until the next completion.
module fmul_unit #(
    parameter int W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [fmul_pkg::MODE_W-1:0] mode,
    input  logic [W-1:0]              op_a,
    input  logic [W-1:0]              op_b,
    output logic [2*W-1:0]            result,
    output logic                      flag_z,
    output logic                      flag_c,
    output logic                      done
);
    import fmul_pkg::*;

    localparam int NOPS = 2;

    logic [W-1:0] raw_ops [NOPS];
    logic         sgn_ops [NOPS];
    logic [W:0]   ext_ops [NOPS];

    logic         accept;
    logic [W:0]   a_q, b_q;
    logic         frac_q, busy;
    logic [2*W-1:0] next_res;
    logic         next_z, next_c;

    // Route operands and their signedness to the extenders.
    always_comb begin
        raw_ops[0] = op_a;
        raw_ops[1] = op_b;
        sgn_ops[0] = first_signed(mode);
        sgn_ops[1] = second_signed(mode);
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_ext
        fmul_operand_ext #(.W(W)) i_ext (
            .val(raw_ops[i]),
            .as_signed(sgn_ops[i]),
            .ext(ext_ops[i])
        );
    end

    // A request is taken only when the capture stage is empty.
    always_comb accept = start && !busy;

    fmul_stage #(.W(W)) i_stage (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .a_in(ext_ops[0]), .b_in(ext_ops[1]), .frac_in(is_fractional(mode)),
        .a_q(a_q), .b_q(b_q), .frac_q(frac_q), .valid_q(busy)
    );

    fmul_shaper #(.W(W)) i_shaper (
        .a_x(a_q), .b_x(b_q), .frac(frac_q),
        .res(next_res), .z(next_z), .c(next_c)
    );

    // Register the outcome on the compute edge and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= busy;
            if (busy) begin
                result <= next_res;
                flag_z <= next_z;
                flag_c <= next_c;
            end
        end
    end

    // A captured operation completes on the very next edge.
    assert_capture_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> done);
    // done only ever follows a capture.
    assert_done_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // Outputs are still unless an operation completes.
    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(result) && $stable(flag_z) && $stable(flag_c)));
    // Without the shift, carry is the top bit of the returned result.
    assert_carry_top_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !frac_q) |-> (flag_c == result[2*W-1]));
    // Zero flag agrees with the registered result.
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (result == '0)));
endmodule

// File: tb/test_fmul_unit.sv
module test_fmul_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] mode = '0;
    logic [7:0] op_a = '0, op_b = '0;
    logic [15:0] result;
    logic flag_z, flag_c, done;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    fmul_unit i_fmul_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .result(result),
        .flag_z(flag_z), .flag_c(flag_c), .done(done)
    );

    // Behavioural reference: value, carry and zero from integer arithmetic.
    function automatic logic [17:0] ref_calc(logic [2:0] m, logic [7:0] a, logic [7:0] b);
        int ia, ib, p;
        logic [15:0] p16, r;
        ia = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
        ib = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
        p = ia * ib;
        p16 = p[15:0];
        r = m[2] ? {p16[14:0], 1'b0} : p16;
        return {(r == 16'h0), p16[15], r};
    endfunction

    function automatic string tag_of(logic [2:0] m);
        if (m[1:0] == 2'b11) return "R11";
        if (m[2]) return "R5";
        case (m[1:0])
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R2";
        endcase
    endfunction

    // Model state, advanced on each edge.
    logic        m_busy = 0, m_done = 0, m_z = 0, m_c = 0;
    logic [15:0] m_res = 0;
    logic [17:0] m_pend = 0;
    logic [2:0]  m_pmode = 0, m_mode = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_res <= 0; m_z <= 0; m_c <= 0;
        end else begin
            m_done <= m_busy;
            if (m_busy) begin
                m_res <= m_pend[15:0]; m_c <= m_pend[16]; m_z <= m_pend[17];
                m_mode <= m_pmode;
            end
            m_busy <= start && !m_busy;
            if (start && !m_busy) begin
                m_pend <= ref_calc(mode, op_a, op_b);
                m_pmode <= mode;
            end
        end
    end

    task automatic check(string tag, logic ok, logic [15:0] act, logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8", done === m_done, {15'b0, done}, {15'b0, m_done});
            check(m_done ? tag_of(m_mode) : "R10", result === m_res, result, m_res);
            check("R6", flag_c === m_c, {15'b0, flag_c}, {15'b0, m_c});
            check("R7", flag_z === m_z, {15'b0, flag_z}, {15'b0, m_z});
        end
    end

    task automatic do_op(logic [2:0] m, logic [7:0] a, logic [7:0] b);
        @(negedge clk); start = 1; mode = m; op_a = a; op_b = b;
        @(negedge clk); start = 0;
        @(negedge clk);
    endtask

    task automatic expect_op(string tag, logic [15:0] r, logic z, logic c);
        check(tag, done === 1'b1, {15'b0, done}, 16'h1);
        check(tag, result === r, result, r);
        check("R7", flag_z === z, {15'b0, flag_z}, {15'b0, z});
        check("R6", flag_c === c, {15'b0, flag_c}, {15'b0, c});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset.
        check("R1", {result, flag_z, flag_c, done} === 19'b0, result, 16'h0);
        rst_n = 1;

        do_op(3'b000, 8'hFF, 8'hFF); expect_op("R2", 16'hFE01, 0, 1);
        do_op(3'b001, 8'h80, 8'h80); expect_op("R3", 16'h4000, 0, 0);
        do_op(3'b001, 8'hFF, 8'h01); expect_op("R3", 16'hFFFF, 0, 1);
        do_op(3'b010, 8'hFF, 8'hFF); expect_op("R4", 16'hFF01, 0, 1);
        do_op(3'b110, 8'h80, 8'hFF); expect_op("R4", 16'h0100, 0, 1);
        do_op(3'b101, 8'h80, 8'h80); expect_op("R5", 16'h8000, 0, 0);
        do_op(3'b100, 8'h40, 8'h40); expect_op("R5", 16'h2000, 0, 0);
        do_op(3'b000, 8'h00, 8'h5A); expect_op("R7", 16'h0000, 1, 0);
        do_op(3'b011, 8'h80, 8'hFF); expect_op("R11", 16'h7F80, 0, 0);
        do_op(3'b111, 8'hC0, 8'hC0); expect_op("R11", 16'h2000, 0, 1);

        // R8: done is a single-cycle pulse.
        @(negedge clk);
        check("R8", done === 1'b0, {15'b0, done}, 16'h0);
        check("R10", result === 16'h2000, result, 16'h2000);

        // R9: a second start in the busy cycle is ignored.
        @(negedge clk); start = 1; mode = 3'b000; op_a = 8'h03; op_b = 8'h05;
        @(negedge clk); op_a = 8'h10; op_b = 8'h10;
        @(negedge clk); start = 0;
        check("R9", result === 16'h000F, result, 16'h000F);
        @(negedge clk);
        check("R9", done === 1'b0, {15'b0, done}, 16'h0);
        check("R9", result === 16'h000F, result, 16'h000F);

        // Random stream, including colliding and reserved-code starts.
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            start = $urandom_range(0, 1) == 1;
            mode = 3'($urandom_range(0, 7));
            op_a = 8'($urandom_range(0, 255));
            op_b = 8'($urandom_range(0, 255));
        end
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule